// File: doc/BRIEF.md
# Planar VRAM Raster-Operation Unit

This unit changes one byte position in a planar frame buffer across as many as four bit-planes with a single trigger. A host first loads a small register set over a write-only configuration port. The registers hold a command byte, per-plane colour bits, a write mask, a plane-skip mask and one tile byte per plane. The host then presents a byte offset and a resolution flag on the trigger port. For every plane that is not skipped, the unit reads the old byte from the frame memory. It forms the new byte from the selected operation, merges it with the old byte under the write mask, and writes the result back.

Two things can restrict a plane or a pixel bit. A plane that is skipped in the register set, or protected by an external page-protect input, receives no memory access at all. When the command asks for it, an externally supplied compare status byte also gates which pixel bits finally change. The frame memory is a plain synchronous port: read data is returned one cycle after the read strobe.

Top module: `vram_rop_unit`

## Requirements
- R1: When command bit 7 is 0, a trigger makes no memory access and leaves every plane unchanged; `done` still pulses for one cycle in the cycle after the trigger.
- R2: Command bits 2:0 select the operation. For each plane, `c` is that plane's colour bit. The codes are: 0 = fill (0xFF if c=1, else 0x00); 1 = clear to 0x00; 2 = OR (0xFF if c=1, else old); 3 = AND (old if c=1, else 0x00); 4 = XOR (inverted old if c=1, else old); 5 = invert old; 6 = that plane's tile byte.
- R3: The written byte is (old AND mask) OR (result AND NOT mask): a mask bit of 1 keeps the old pixel bit.
- R4: A plane whose bit is 1 in the plane-skip register (bits 3:0, bit n = plane n) is neither read nor written. Only planes 0 to 3 exist.
- R5: A plane n (n < 3) whose bit n is 1 on `page_protect` is neither read nor written.
- R6: With command bit 6 set, each bit where `cmp_status` is 1 keeps its old value when command bit 5 is 1, and takes the R3 value when command bit 5 is 0. Each bit where `cmp_status` is 0 does the opposite. With bit 6 clear, `cmp_status` has no effect.
- R7: With `trig_hires`=1 the memory address of plane p is p*0x8000 + `trig_addr`[14:0]. With `trig_hires`=0 it is p*0x4000 + `trig_addr`[13:0].
- R8: Enabled planes are served in ascending order. Each gets one read cycle followed by one write cycle to the same address. `busy` is high for exactly 2*N cycles for N served planes, starting the cycle after the trigger. `done` is high for one cycle right after the last write, with `busy` low.
- R9: A trigger that arrives while `busy` is high is ignored: it neither changes the address in use nor starts another operation.
- R10: Operation code 7 (compare) makes no memory access; `done` pulses in the cycle after the trigger.
- R11: Configuration select codes: 0 = command, 1 = colour (bit n = plane n), 2 = write mask, 3 = plane-skip, 4+n = tile byte of plane n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Configuration register select (R11) |
| cfg_wdata | input | 8 | Configuration write data |
| page_protect | input | 3 | Per-plane protection for planes 0..2 |
| cmp_status | input | 8 | Per-pixel compare result used for gated writes |
| trig | input | 1 | Start an operation (taken only when idle) |
| trig_addr | input | 15 | Byte offset within a plane |
| trig_hires | input | 1 | 1 = 0x8000-byte planes, 0 = 0x4000-byte planes |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A trigger sampled at a clock edge puts the first read strobe and `busy` out in the following cycle. The matching write follows one cycle later, so N planes keep `busy` up for 2*N cycles and `done` appears in cycle 2*N+1. With no plane to serve, `done` appears in cycle 1. The bench drives on falling edges and counts `busy` cycles at each falling edge until `done` shows. It compares that count with twice the number of planes it expects to be served. It then checks every plane byte of the addressed offset in its own memory model against values computed from the requirements. A monitor counts the write strobes and checks that their addresses ascend.

// File: rtl/rop_pkg.sv
package rop_pkg;

  typedef enum logic [2:0] {
    OP_FILL  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_OR    = 3'd2,
    OP_AND   = 3'd3,
    OP_XOR   = 3'd4,
    OP_INV   = 3'd5,
    OP_TILE  = 3'd6,
    OP_CMP   = 3'd7
  } rop_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } rop_state_e;

  localparam int CMD_EN_BIT   = 7;
  localparam int CMD_GATE_BIT = 6;
  localparam int CMD_KEEP_BIT = 5;

  localparam int SEL_CMD    = 0;
  localparam int SEL_COLOUR = 1;
  localparam int SEL_MASK   = 2;
  localparam int SEL_SKIP   = 3;
  localparam int SEL_TILE0  = 4;

endpackage

// File: rtl/rop_regs.sv
module rop_regs
  import rop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter int SEL_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [7:0]                     cmd_o,
  output logic [PLANES-1:0]              colour_o,
  output logic [DATA_W-1:0]              wmask_o,
  output logic [PLANES-1:0]              skip_o,
  output logic [PLANES-1:0][DATA_W-1:0]  tile_o
);

  logic [7:0]                    cmd_q;
  logic [PLANES-1:0]             colour_q;
  logic [DATA_W-1:0]             wmask_q;
  logic [PLANES-1:0]             skip_q;
  logic [PLANES-1:0][DATA_W-1:0] tile_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      colour_q <= '0;
      wmask_q  <= '0;
      skip_q   <= '0;
      tile_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(SEL_CMD))    cmd_q    <= wr_data[7:0];
      if (wr_sel == SEL_W'(SEL_COLOUR)) colour_q <= wr_data[PLANES-1:0];
      if (wr_sel == SEL_W'(SEL_MASK))   wmask_q  <= wr_data;
      if (wr_sel == SEL_W'(SEL_SKIP))   skip_q   <= wr_data[PLANES-1:0];
      for (int p = 0; p < PLANES; p++) begin
        if (wr_sel == SEL_W'(SEL_TILE0 + p)) tile_q[p] <= wr_data;
      end
    end
  end

  assign cmd_o    = cmd_q;
  assign colour_o = colour_q;
  assign wmask_o  = wmask_q;
  assign skip_o   = skip_q;
  assign tile_o   = tile_q;

endmodule

// File: rtl/rop_alu.sv
module rop_alu
  import rop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rop_op_e           op,
  input  logic              colour_bit,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] tile,
  input  logic              gate_en,
  input  logic              gate_keep_on_one,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] new_data
);

  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] keep_sel;

  always_comb begin
    unique case (op)
      OP_FILL:  result = colour_bit ? '1 : '0;
      OP_CLEAR: result = '0;
      OP_OR:    result = colour_bit ? '1 : old_data;
      OP_AND:   result = colour_bit ? old_data : '0;
      OP_XOR:   result = colour_bit ? ~old_data : old_data;
      OP_INV:   result = ~old_data;
      OP_TILE:  result = tile;
      default:  result = old_data;
    endcase
    merged = (old_data & wmask) | (result & ~wmask);
    if (gate_en) begin
      keep_sel = gate_keep_on_one ? status : ~status;
      new_data = (old_data & keep_sel) | (merged & ~keep_sel);
    end else begin
      keep_sel = '0;
      new_data = merged;
    end
  end

  always_comb begin
    if (!gate_en) begin
      AST_MASK_KEEPS: assert ((new_data & wmask) == (old_data & wmask)); // R3
    end
  end

endmodule

// File: rtl/rop_seq.sv
module rop_seq
  import rop_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int ADDR_W  = 15,
  parameter int PLANE_W = $clog2(PLANES),
  parameter int MEM_AW  = ADDR_W + PLANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [ADDR_W-1:0]  trig_addr,
  input  logic               trig_hires,
  input  logic               enable,
  input  rop_op_e            op,
  input  logic [PLANES-1:0]  skip,
  output logic               busy,
  output logic               done,
  output logic               mem_re,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [PLANE_W-1:0] plane
);

  rop_state_e          state_q, state_d;
  logic [PLANE_W-1:0]  plane_q, plane_d;
  logic [PLANES-1:0]   pend_q, pend_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                hires_q, hires_d;
  logic                done_q, done_d;
  logic [PLANES-1:0]   work;

  function automatic logic [PLANE_W-1:0] lowest_set(input logic [PLANES-1:0] v);
    logic [PLANE_W-1:0] idx;
    idx = '0;
    for (int i = PLANES - 1; i >= 0; i--) begin
      if (v[i]) idx = PLANE_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    state_d = state_q;
    plane_d = plane_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    hires_d = hires_q;
    done_d  = 1'b0;
    work    = (enable && op != OP_CMP) ? ~skip : '0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          addr_d  = trig_addr;
          hires_d = trig_hires;
          if (|work) begin
            state_d = ST_RD;
            plane_d = lowest_set(work);
            pend_d  = work;
            pend_d[lowest_set(work)] = 1'b0;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_RD: state_d = ST_WR;
      ST_WR: begin
        if (|pend_q) begin
          state_d = ST_RD;
          plane_d = lowest_set(pend_q);
          pend_d[lowest_set(pend_q)] = 1'b0;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plane_q <= '0;
      pend_q  <= '0;
      addr_q  <= '0;
      hires_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      plane_q <= plane_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d;
      hires_q <= hires_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign mem_re   = (state_q == ST_RD);
  assign mem_we   = (state_q == ST_WR);
  assign plane    = plane_q;
  assign mem_addr = hires_q ? {plane_q, addr_q} : {1'b0, plane_q, addr_q[ADDR_W-2:0]};

  AST_RD_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re)); // R8
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == $past(mem_addr)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_NO_SKIPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> !skip[plane]); // R4
  AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> $stable(addr_q)); // R9

endmodule

// File: rtl/vram_rop_unit.sv
module vram_rop_unit
  import rop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter int ADDR_W = 15,
  parameter int PROT_W = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(SEL_TILE0+PLANES)-1:0] cfg_sel,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  input  logic [PROT_W-1:0]                  page_protect,
  input  logic [DATA_W-1:0]                  cmp_status,
  input  logic                               trig,
  input  logic [ADDR_W-1:0]                  trig_addr,
  input  logic                               trig_hires,
  input  logic [DATA_W-1:0]                  mem_rdata,
  output logic                               mem_re,
  output logic                               mem_we,
  output logic [ADDR_W+$clog2(PLANES)-1:0]   mem_addr,
  output logic [DATA_W-1:0]                  mem_wdata,
  output logic                               busy,
  output logic                               done
);

  localparam int PLANE_W = $clog2(PLANES);
  localparam int MEM_AW  = ADDR_W + PLANE_W;
  localparam int SEL_W   = $clog2(SEL_TILE0 + PLANES);

  logic [1:0]                    rst_pipe;
  logic                          rst_sync_n;
  logic [7:0]                    cmd;
  logic [PLANES-1:0]             colour;
  logic [DATA_W-1:0]             wmask;
  logic [PLANES-1:0]             skip_reg;
  logic [PLANES-1:0][DATA_W-1:0] tile;
  logic [PLANES-1:0]             skip_all;
  logic [PLANE_W-1:0]            plane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar p = 0; p < PLANES; p++) begin : g_skip
    if (p < PROT_W) begin : g_prot
      assign skip_all[p] = skip_reg[p] | page_protect[p];
    end else begin : g_noprot
      assign skip_all[p] = skip_reg[p];
    end
  end

  rop_regs #(.DATA_W(DATA_W), .PLANES(PLANES), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_wdata),
    .cmd_o    (cmd),
    .colour_o (colour),
    .wmask_o  (wmask),
    .skip_o   (skip_reg),
    .tile_o   (tile)
  );

  rop_seq #(.PLANES(PLANES), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig       (trig),
    .trig_addr  (trig_addr),
    .trig_hires (trig_hires),
    .enable     (cmd[CMD_EN_BIT]),
    .op         (rop_op_e'(cmd[2:0])),
    .skip       (skip_all),
    .busy       (busy),
    .done       (done),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .plane      (plane)
  );

  rop_alu #(.DATA_W(DATA_W)) u_alu (
    .op               (rop_op_e'(cmd[2:0])),
    .colour_bit       (colour[plane]),
    .old_data         (mem_rdata),
    .wmask            (wmask),
    .tile             (tile[plane]),
    .gate_en          (cmd[CMD_GATE_BIT]),
    .gate_keep_on_one (cmd[CMD_KEEP_BIT]),
    .status           (cmp_status),
    .new_data         (mem_wdata)
  );

  AST_PROTECTED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_we && PLANE_W'(plane) < PLANE_W'(PROT_W)) |-> !page_protect[plane]); // R5
  AST_CMP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd[2:0] == 3'd7 && !busy) |=> !mem_re); // R10

endmodule

// File: tb/tb_vram_rop_unit.sv
module tb_vram_rop_unit;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [2:0]  page_protect;
  logic [7:0]  cmp_status;
  logic        trig;
  logic [14:0] trig_addr;
  logic        trig_hires;
  logic [7:0]  mem_rdata;
  logic        mem_re;
  logic        mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] vram [int unsigned];
  int         we_cnt;
  bit         order_bad;
  int unsigned last_wa;

  logic [7:0] s_cmd, s_col, s_msk, s_skip;
  logic [7:0] s_tile [4];

  vram_rop_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .page_protect(page_protect), .cmp_status(cmp_status), .trig(trig),
    .trig_addr(trig_addr), .trig_hires(trig_hires), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] peek(int unsigned a);
    if (vram.exists(a)) return vram[a];
    return 8'(a * 13 + (a >> 5) + 32'h5A);
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      vram[32'(mem_addr)] = mem_wdata;
      if (we_cnt > 0 && 32'(mem_addr) <= last_wa) order_bad = 1;
      last_wa = 32'(mem_addr);
      we_cnt++;
    end
    if (mem_re) mem_rdata <= peek(32'(mem_addr));
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model(int p, logic [7:0] old, logic [7:0] st);
    logic [7:0] res, mrg, keep;
    logic c;
    c = s_col[p];
    case (s_cmd[2:0])
      3'd0: res = c ? 8'hFF : 8'h00;
      3'd1: res = 8'h00;
      3'd2: res = c ? 8'hFF : old;
      3'd3: res = c ? old : 8'h00;
      3'd4: res = c ? ~old : old;
      3'd5: res = ~old;
      3'd6: res = s_tile[p];
      default: res = old;
    endcase
    mrg = (old & s_msk) | (res & ~s_msk);
    if (s_cmd[6]) begin
      keep = s_cmd[5] ? st : ~st;
      return (old & keep) | (mrg & ~keep);
    end
    return mrg;
  endfunction

  task automatic wr_reg(int sel, logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: s_cmd = v;
      1: s_col = v;
      2: s_msk = v;
      3: s_skip = v;
      default: s_tile[sel-4] = v;
    endcase
  endtask

  task automatic setup(logic [7:0] cmd, logic [7:0] col, logic [7:0] msk, logic [7:0] skp);
    wr_reg(0, cmd); wr_reg(1, col); wr_reg(2, msk); wr_reg(3, skp);
  endtask

  task automatic run_op(logic [14:0] a, bit hi, bit inject, string req);
    int unsigned pa [4];
    logic [7:0]  expv [4];
    logic [7:0]  ghost_old [4];
    int unsigned ghost [4];
    int n, cyc, wd;
    bit act, got_done;
    logic [14:0] a2;
    n = 0;
    a2 = a ^ 15'h0123;
    for (int p = 0; p < 4; p++) begin
      pa[p] = hi ? (p * 32'h8000 + 32'(a)) : (p * 32'h4000 + 32'(a[13:0]));
      ghost[p] = hi ? (p * 32'h8000 + 32'(a2)) : (p * 32'h4000 + 32'(a2[13:0]));
      ghost_old[p] = peek(ghost[p]);
      act = s_cmd[7] && s_cmd[2:0] != 3'd7 && !s_skip[p] && !(p < 3 && page_protect[p]);
      expv[p] = act ? model(p, peek(pa[p]), cmp_status) : peek(pa[p]);
      if (act) n++;
    end
    if (n == 0) inject = 0;
    we_cnt = 0; order_bad = 0;
    @(negedge clk);
    trig = 1; trig_addr = a; trig_hires = hi;
    @(negedge clk);
    if (inject) trig_addr = a2; else trig = 0;
    cyc = 0; got_done = 0;
    for (wd = 0; wd < 40; wd++) begin
      if (wd == 1) trig = 0;
      if (busy) cyc++;
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    trig = 0;
    check(got_done, "R8", "done pulse seen", int'(got_done), 1);
    check(cyc == 2 * n, req, "busy cycles (R8)", cyc, 2 * n);
    check(we_cnt == n, req, "write count", we_cnt, n);
    check(!order_bad, "R8", "ascending plane order", int'(order_bad), 0);
    for (int p = 0; p < 4; p++) begin
      check(peek(pa[p]) == expv[p], req, $sformatf("plane %0d byte", p),
            int'(peek(pa[p])), int'(expv[p]));
      if (inject)
        check(peek(ghost[p]) == ghost_old[p], "R9", "late trigger address untouched",
              int'(peek(ghost[p])), int'(ghost_old[p]));
    end
    @(negedge clk);
    check(!done && !busy, "R8", "done is one cycle", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; page_protect = 0;
    cmp_status = 0; trig = 0; trig_addr = 0; trig_hires = 0;
    we_cnt = 0; order_bad = 0; last_wa = 0;
    s_cmd = 0; s_col = 0; s_msk = 0; s_skip = 0;
    for (int i = 0; i < 4; i++) s_tile[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R8", "reset outputs idle",
          {busy, done, mem_re, mem_we}, 0);

    // R1: unit disabled
    setup(8'h00, 8'h0F, 8'h00, 8'h00);
    run_op(15'h0100, 1, 0, "R1");

    // R11: tile registers per plane
    wr_reg(4, 8'h3C); wr_reg(5, 8'hA5); wr_reg(6, 8'h0F); wr_reg(7, 8'hE1);

    // R2/R3/R7: every operation, both resolutions, mask 0x0F
    for (int op = 0; op < 7; op++) begin
      setup(8'h80 | 8'(op), 8'h05, 8'h0F, 8'h00);
      run_op(15'(16'h4321 + op * 7), 1, 0, "R2");
      run_op(15'(16'h7ABC + op * 5), 0, 0, "R7");
    end
    setup(8'h86, 8'h00, 8'h00, 8'h00);
    run_op(15'h0040, 1, 0, "R11");
    setup(8'h84, 8'h0A, 8'hC3, 8'h00);
    run_op(15'h1234, 1, 0, "R3");

    // R4: skip planes 1 and 3
    setup(8'h80, 8'h0F, 8'h00, 8'h0A);
    run_op(15'h2222, 1, 0, "R4");
    setup(8'h80, 8'h0F, 8'h00, 8'h0F);
    run_op(15'h2223, 0, 0, "R4");

    // R5: page protect
    page_protect = 3'b101;
    setup(8'h85, 8'h00, 8'h00, 8'h00);
    run_op(15'h3333, 1, 0, "R5");
    page_protect = 3'b000;

    // R6: compare gated, both polarities, and gate off
    cmp_status = 8'hC3;
    setup(8'hE0, 8'h0F, 8'h00, 8'h00);
    run_op(15'h0505, 1, 0, "R6");
    setup(8'hC0, 8'h0F, 8'h00, 8'h00);
    run_op(15'h0606, 1, 0, "R6");
    setup(8'h80, 8'h0F, 8'h00, 8'h00);
    run_op(15'h0707, 1, 0, "R6");
    cmp_status = 8'h00;

    // R10: compare code makes no access
    setup(8'h87, 8'h0F, 8'h00, 8'h00);
    run_op(15'h0808, 1, 0, "R10");

    // R9: trigger held during busy with another address
    setup(8'h85, 8'h00, 8'h00, 8'h00);
    run_op(15'h1111, 1, 1, "R9");

    // random mix
    void'($urandom(32'd12345));
    for (int it = 0; it < 60; it++) begin
      logic [7:0] c;
      c = 8'($urandom);
      c[7] = ($urandom % 10) < 8;
      c[4:3] = 2'b00;
      page_protect = 3'($urandom);
      cmp_status = 8'($urandom);
      setup(c, 8'($urandom), 8'($urandom), 8'($urandom % 16));
      wr_reg(4 + int'($urandom % 4), 8'($urandom));
      run_op(15'($urandom), 1'($urandom), 1'($urandom), "R2");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule